// File: doc/BRIEF.md
# Dual-Clock Buffer with Programmable Fill Flags

This block is a first-in first-out buffer of 9-bit words with a write side and a read side, each on its own clock. The two clocks may be one net or may be unrelated. Each side keeps its own binary pointer and passes a Gray-coded copy to the other side through a two-stage synchronizer. The write side therefore computes Full and Almost-Full, and the read side computes Empty and Almost-Empty. The depth is set as a power of two by `ADDR_W`. Values from 8 to 13 give 256 to 8192 words, and any value of 3 or more is legal.

A write needs both write inputs high. When the second write input is low while the first is high, the same clock edge instead loads an offset register. The two loads alternate: the almost-empty offset first, then the almost-full offset. A read needs both read inputs high. It moves the addressed word into an output register. When the output-enable input is low the data output reads as zero, and the register keeps its value. An active-low asynchronous reset clears both pointers and sets both offsets back to 7.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While reset is low, and directly after it, `empty`=1, `almostEmpty`=1, `full`=0, `almostFull`=0 and `rdData`=0. Reset also restores both offsets to 7 and points the load sequence at the almost-empty offset.
- R2: A rising `wrClk` edge with `wrEnA`=1, `wrLdN`=1 and `full`=0 stores `wrData`. Words leave the buffer in the order they were stored.
- R3: A rising `rdClk` edge with `rdEnA`=1, `rdEnB`=1 and `empty`=0 loads the oldest word into the output register. `rdData` shows that word from this edge on, and holds it until the next accepted read.
- R4: `full` is 1 once the buffer holds 2^ADDR_W words. A write attempted while full stores nothing and changes no stored word.
- R5: A read attempted while `empty`=1 is ignored, and `rdData` keeps its value.
- R6: `almostEmpty` is 1 exactly when the fill level is less than or equal to the almost-empty offset.
- R7: `almostFull` is 1 exactly when the fill level is greater than or equal to 2^ADDR_W minus the almost-full offset.
- R8: A rising `wrClk` edge with `wrEnA`=1 and `wrLdN`=0 stores no data word. Instead it loads the low ADDR_W bits of `wrData` into an offset register. Successive loads go to the almost-empty offset, then the almost-full offset, then back again.
- R9: With `outEn`=0, `rdData` is 0. Raising `outEn` again shows the word held in the output register.
- R10: With `rdClk` unrelated in frequency and phase to `wrClk`, a stream longer than the depth passes through complete and in order.
- R11: A read input raised alone (`rdEnA` without `rdEnB`, or the reverse) reads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, may equal wrClk |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 9 | Word to store, or offset value when loading |
| wrEnA | input | 1 | First write enable, active high |
| wrLdN | input | 1 | Second write enable when high; selects offset loading when low |
| rdEnA | input | 1 | First read enable, active high |
| rdEnB | input | 1 | Second read enable, active high |
| outEn | input | 1 | Output drive enable; output reads as zero when low |
| rdData | output | 9 | Output register contents, gated by outEn |
| empty | output | 1 | No words held (read domain) |
| almostEmpty | output | 1 | Fill level at or below the almost-empty offset (read domain) |
| full | output | 1 | All words in use (write domain) |
| almostFull | output | 1 | Fill level at or above depth minus the almost-full offset (write domain) |

## Verification
The bench builds the block with `ADDR_W`=4, a 16-word buffer. At this size the default offset of 7 places the almost-empty edge between levels 7 and 8 and the almost-full edge between levels 8 and 9, so every flag edge, filling to full and pointer wrap are reached in a few hundred cycles. A loaded pair of offsets (2 and 12) moves both edges to levels that the defaults would flag differently. This shows both the load order and the restore on reset. The asynchronous phase runs the read clock at a 14 ns period against the 10 ns write clock and streams 40 words, which wraps the pointers more than twice.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  localparam int DATA_W = 9;
  localparam int OFFSET_RESET = 7;

  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
    logic ldAe;
    logic ldAf;
  } fifoStb_t;
endpackage

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W = 5
) (
  input  logic         dstClk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge dstClk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrLdN,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] aeOff,
  input  logic [ADDR_W-1:0] afOff,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              empty,
  output logic              almostEmpty,
  output logic              full,
  output logic              almostFull
);
  localparam int PW = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PW-1:0] wrBin, wrGray, rdGrayW, rdBinW, wrLevel, afThresh;
  logic          ldSelAf, loadReq;

  fifo_ptr_sync #(.W(PW)) u_syncRdToWr (
    .dstClk(wrClk), .rstN(rstN), .din(rdGrayInt), .dout(rdGrayW)
  );

  always_comb begin
    rdBinW   = fromGray(rdGrayW);
    wrLevel  = wrBin - rdBinW;
    afThresh = DEPTH_P - {1'b0, afOff};
    full       = (wrLevel == DEPTH_P);
    almostFull = (wrLevel >= afThresh);
    loadReq      = wrEnA && !wrLdN;
    stb.wrAccept = wrEnA && wrLdN && !full;
    stb.ldAe     = loadReq && !ldSelAf;
    stb.ldAf     = loadReq && ldSelAf;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      ldSelAf <= 1'b0;
    end else begin
      if (stb.wrAccept) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
      if (loadReq) ldSelAf <= !ldSelAf;
    end
  end

  // read domain
  logic [PW-1:0] rdBin, rdGrayInt, wrGrayR, wrBinR, rdLevel;

  fifo_ptr_sync #(.W(PW)) u_syncWrToRd (
    .dstClk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGrayR)
  );

  always_comb begin
    wrBinR      = fromGray(wrGrayR);
    rdLevel     = wrBinR - rdBin;
    empty       = (rdLevel == '0);
    almostEmpty = (rdLevel <= {1'b0, aeOff});
    stb.rdAccept = rdEnA && rdEnB && !empty;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin     <= '0;
      rdGrayInt <= '0;
    end else if (stb.rdAccept) begin
      rdBin     <= rdBin + 1'b1;
      rdGrayInt <= toGray(rdBin + 1'b1);
    end
  end

  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] aeOff,
  output logic [ADDR_W-1:0] afOff
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'(OFFSET_RESET);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.wrAccept) store[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= OFF_RST;
      afOff <= OFF_RST;
    end else begin
      if (stb.ldAe) aeOff <= ADDR_W'(wrData);
      if (stb.ldAf) afOff <= ADDR_W'(wrData);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (stb.rdAccept) outReg <= store[rdAddr];
  end

  assign rdData = outEn ? outReg : '0;
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEnA,
  input  logic              wrLdN,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty,
  output logic              full,
  output logic              almostFull
);
  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, aeOff, afOff;

  fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrLdN(wrLdN), .rdEnA(rdEnA), .rdEnB(rdEnB),
    .aeOff(aeOff), .afOff(afOff), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .empty(empty), .almostEmpty(almostEmpty),
    .full(full), .almostFull(almostFull)
  );

  fifo_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .outEn(outEn),
    .rdData(rdData), .aeOff(aeOff), .afOff(afOff)
  );
endmodule

// File: rtl/fifo_chk.sv
module fifo_chk (
  input logic       wrClk,
  input logic       rdClk,
  input logic       rstN,
  input logic       wrEnA,
  input logic       wrLdN,
  input logic       outEn,
  input logic [8:0] rdData,
  input logic       empty,
  input logic       almostEmpty,
  input logic       full,
  input logic       almostFull,
  input logic       stbWr
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> !stbWr); // R4
  AST_LOAD_STORES_NOTHING: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEnA && !wrLdN) |-> !stbWr); // R8
  AST_EMPTY_READ_HOLDS: assert property (@(posedge rdClk) disable iff (!rstN)
    (empty && outEn) |=> (!outEn || $stable(rdData))); // R5
  AST_EMPTY_IS_ALMOST: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty); // R6
  AST_FULL_IS_ALMOST: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull); // R7
endmodule

bind dual_clock_flag_fifo fifo_chk u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEnA(wrEnA), .wrLdN(wrLdN),
  .outEn(outEn), .rdData(rdData), .empty(empty), .almostEmpty(almostEmpty),
  .full(full), .almostFull(almostFull), .stbWr(stb.wrAccept)
);

// File: tb/dual_clock_flag_fifo_tb.sv
module dual_clock_flag_fifo_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic       wrClk = 0, rdClk = 0, rstN = 0;
  logic [8:0] wrData = 0;
  logic       wrEnA = 0, wrLdN = 1, rdEnA = 0, rdEnB = 0, outEn = 1;
  logic [8:0] rdData;
  logic       empty, almostEmpty, full, almostFull;
  int         rdHalf = 5;
  int         total = 0, bad = 0;
  int         model[$];

  dual_clock_flag_fifo #(.ADDR_W(AW)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrData(wrData),
    .wrEnA(wrEnA), .wrLdN(wrLdN), .rdEnA(rdEnA), .rdEnB(rdEnB),
    .outEn(outEn), .rdData(rdData), .empty(empty),
    .almostEmpty(almostEmpty), .full(full), .almostFull(almostFull)
  );

  always #5 wrClk = ~wrClk;
  initial forever #(rdHalf) rdClk = ~rdClk;

  function automatic logic [8:0] pattern(int n);
    return 9'((n * 37 + 5) & 9'h1FF);
  endfunction

  task automatic checkEq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wrClk);
  endtask

  task automatic doReset();
    @(negedge wrClk) rstN = 0;
    repeat (2) @(negedge wrClk);
    rstN = 1;
    model.delete();
    @(negedge wrClk);
  endtask

  task automatic pushWord(logic [8:0] d);
    @(negedge wrClk);
    wrData = d; wrEnA = 1; wrLdN = 1;
    @(negedge wrClk) wrEnA = 0;
  endtask

  task automatic popWord(output int d);
    @(negedge rdClk);
    rdEnA = 1; rdEnB = 1;
    @(negedge rdClk);
    rdEnA = 0; rdEnB = 0;
    d = int'(rdData);
  endtask

  task automatic testReset();
    rstN = 0;
    #3;
    checkEq("R1 empty in reset", int'(empty), 1);
    checkEq("R1 full in reset", int'(full), 0);
    doReset();
    checkEq("R1 empty", int'(empty), 1);
    checkEq("R1 almostEmpty", int'(almostEmpty), 1);
    checkEq("R1 full", int'(full), 0);
    checkEq("R1 almostFull", int'(almostFull), 0);
    checkEq("R1 rdData", int'(rdData), 0);
  endtask

  task automatic testFillDrain();
    int d, last;
    doReset();
    for (int i = 1; i <= DEPTH; i++) begin
      pushWord(pattern(i));
      model.push_back(int'(pattern(i)));
      settle();
      if (i == 1) checkEq("R2 empty drops after write", int'(empty), 0);
      if (i == 7) checkEq("R6 AE at level 7", int'(almostEmpty), 1);
      if (i == 8) checkEq("R6 AE at level 8", int'(almostEmpty), 0);
      if (i == 8) checkEq("R7 AF at level 8", int'(almostFull), 0);
      if (i == 9) checkEq("R7 AF at level 9", int'(almostFull), 1);
      if (i == DEPTH - 1) checkEq("R4 not full at depth-1", int'(full), 0);
    end
    checkEq("R4 full at depth", int'(full), 1);
    pushWord(9'h1AA);
    settle();
    checkEq("R4 still full after extra write", int'(full), 1);
    popWord(d);
    checkEq("R3 first word out", d, model.pop_front());
    last = d;
    @(negedge rdClk) rdEnA = 1;
    @(negedge rdClk) rdEnA = 0;
    checkEq("R11 rdEnA alone holds rdData", int'(rdData), last);
    @(negedge rdClk) rdEnB = 1;
    @(negedge rdClk) rdEnB = 0;
    checkEq("R11 rdEnB alone holds rdData", int'(rdData), last);
    while (model.size() > 0) begin
      popWord(d);
      checkEq("R2 R4 order after full", d, model.pop_front());
      last = d;
    end
    settle();
    checkEq("R4 extra write not stored", int'(empty), 1);
    popWord(d);
    checkEq("R5 read while empty holds", d, last);
    checkEq("R5 still empty", int'(empty), 1);
    @(negedge rdClk) outEn = 0;
    #1 checkEq("R9 output gated to zero", int'(rdData), 0);
    @(negedge rdClk) outEn = 1;
    #1 checkEq("R9 output restored", int'(rdData), last);
  endtask

  task automatic testLoad();
    int d;
    doReset();
    @(negedge wrClk);
    wrData = 9'd2; wrEnA = 1; wrLdN = 0;
    @(negedge wrClk) wrData = 9'd12;
    @(negedge wrClk);
    wrEnA = 0; wrLdN = 1;
    settle();
    checkEq("R8 load writes no data", int'(empty), 1);
    for (int i = 1; i <= 4; i++) begin
      pushWord(pattern(100 + i));
      model.push_back(int'(pattern(100 + i)));
      settle();
      if (i == 2) checkEq("R8 R6 AE at loaded level 2", int'(almostEmpty), 1);
      if (i == 3) checkEq("R8 R6 AE at level 3", int'(almostEmpty), 0);
      if (i == 3) checkEq("R8 R7 AF at level 3", int'(almostFull), 0);
      if (i == 4) checkEq("R8 R7 AF at loaded level 4", int'(almostFull), 1);
    end
    while (model.size() > 0) begin
      popWord(d);
      checkEq("R8 data after load", d, model.pop_front());
    end
    doReset();
    checkEq("R1 empty after second reset", int'(empty), 1);
    for (int i = 1; i <= 8; i++) begin
      pushWord(pattern(200 + i));
      settle();
      if (i == 7) checkEq("R1 AE offset restored, level 7", int'(almostEmpty), 1);
      if (i == 8) checkEq("R1 AE offset restored, level 8", int'(almostEmpty), 0);
      if (i == 8) checkEq("R1 AF offset restored, level 8", int'(almostFull), 0);
    end
  endtask

  task automatic testAsync();
    int errs = 0;
    doReset();
    rdHalf = 7;
    fork
      begin
        int n = 0;
        while (n < 40) begin
          @(negedge wrClk);
          if (!full) begin
            wrData = pattern(300 + n); wrEnA = 1; wrLdN = 1; n++;
          end else wrEnA = 0;
        end
        @(negedge wrClk) wrEnA = 0;
      end
      begin
        int m = 0;
        bit pend = 0;
        while (m < 40) begin
          @(negedge rdClk);
          if (pend) begin
            if (int'(rdData) != int'(pattern(300 + m))) begin
              errs++;
              checkEq("R10 async stream word", int'(rdData), int'(pattern(300 + m)));
            end
            m++;
          end
          pend = 0; rdEnA = 0; rdEnB = 0;
          if (m < 40 && !empty) begin
            rdEnA = 1; rdEnB = 1; pend = 1;
          end
        end
        rdEnA = 0; rdEnB = 0;
      end
    join
    checkEq("R10 async stream mismatches", errs, 0);
    repeat (6) @(negedge rdClk);
    checkEq("R10 empty after stream", int'(empty), 1);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testFillDrain();
    testLoad();
    testAsync();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule